// File: doc/BRIEF.md
# Configurable Slice Storage Bank

This block is a behavioural model of the storage site inside one logic slice. It holds eight single-bit storage elements. Four sit in primary positions and can work as edge-triggered flip-flops or as level-sensitive latches. Four sit in secondary positions and work only as flip-flops. A handful of site-wide mode bits sets how every element behaves: latch or flip-flop, synchronous or immediate set/reset, clock polarity, whether the clock enable is honoured, and whether the set/reset input is honoured. Two per-element selector vectors choose the level that set/reset forces and the level that a global set/reset loads.

Two encodings swap meaning when the site is in latch mode. The clock-invert bit selects the falling edge in flip-flop mode, but in latch mode a 1 keeps the gate un-inverted. The initial-value selector loads its complement in flip-flop mode and its own value in latch mode. Global set/reset has the highest priority, set/reset comes next, and clock enable with data comes last. While latch mode is selected, the secondary elements drive 0.

Top module: `slice_storage_bank`

## Requirements
- R1: In flip-flop mode (`mode_latch`=0), asserting `gsr_in` immediately forces each `q_out[i]` to the inverse of `elem_init_sel[i]` (selector 0 gives 1, selector 1 gives 0).
- R2: In latch mode (`mode_latch`=1), asserting `gsr_in` forces each primary `q_out[i]` (i=0..3) to `elem_init_sel[i]` itself.
- R3: In flip-flop mode, data is captured on the rising clock edge when `mode_clk_inv`=0 and on the falling edge when `mode_clk_inv`=1. No change occurs on the other edge.
- R4: In latch mode, a primary element is transparent while its gate is high and holds its value otherwise. The gate equals `clk` when `mode_clk_inv`=1 and the inverse of `clk` when `mode_clk_inv`=0, and it is qualified by the effective clock enable.
- R5: With `mode_sync_sr`=1 in flip-flop mode, set/reset changes the outputs only at the capture edge. With `mode_sync_sr`=0, and always in latch mode, it acts at once.
- R6: While set/reset is effective, each element goes to 0 when `elem_rst_sel[i]`=1 and to 1 when `elem_rst_sel[i]`=0.
- R7: With `mode_use_ce`=0 the enable is treated as always high. With `mode_use_ce`=1, a low `ce_in` makes every element hold its value.
- R8: With `mode_use_sr`=0, `sr_in` has no effect on any element.
- R9: Priority is `gsr_in` over effective set/reset, and effective set/reset over clock enable and data.
- R10: In latch mode the secondary outputs `q_out[7:4]` are 0 whatever `d_in[7:4]` carries.
- R11: Every combination of the five site-wide mode bits behaves as R1 to R10 predict for all eight elements.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Site clock (latch gate source in latch mode) |
| gsr_in | input | 1 | Global set/reset, active high, asynchronous |
| ce_in | input | 1 | Shared clock / gate enable |
| sr_in | input | 1 | Shared set/reset, active high |
| d_in | input | 8 | Data inputs, bits 3:0 primary, 7:4 secondary |
| mode_latch | input | 1 | 1: primary elements are latches, secondaries off |
| mode_sync_sr | input | 1 | 1: flip-flop set/reset acts at the capture edge only |
| mode_clk_inv | input | 1 | Clock polarity bit, meaning depends on `mode_latch` |
| mode_use_ce | input | 1 | 1: honour `ce_in`; 0: enable always high |
| mode_use_sr | input | 1 | 1: honour `sr_in`; 0: set/reset never active |
| elem_rst_sel | input | 8 | Per element: 1 resets to 0, 0 sets to 1 |
| elem_init_sel | input | 8 | Per element global set/reset value selector |
| q_out | output | 8 | Element outputs |

## Verification
The assertions assume that the mode bits and the per-element selectors change only while `gsr_in` is high, so no spurious clock or gate edge from a polarity change can land outside a global reset. They also assume that `ce_in`, `sr_in` and `d_in` change once per cycle, away from both clock edges, and that `gsr_in` is held for at least two falling edges whenever it is meant to be checked. The stimulus applies every new mode under a global reset that lasts a full cycle and drives the data pins one nanosecond after each rising edge. This keeps every capture edge and every latch-open window on stable inputs.

// File: rtl/slice_store_pkg.sv
package slice_store_pkg;

  typedef struct packed {
    logic latch;
    logic sync_sr;
    logic clk_inv;
    logic use_ce;
    logic use_sr;
  } site_mode_t;

  // Value forced by set/reset: selector 1 means clear.
  function automatic logic sr_level(input logic sel);
    return ~sel;
  endfunction

  // Value loaded on global set/reset; polarity flips between modes.
  function automatic logic gsr_level(input logic sel, input logic is_latch);
    return is_latch ? sel : ~sel;
  endfunction

endpackage

// File: rtl/slice_site_ctrl.sv
module slice_site_ctrl
  import slice_store_pkg::*;
(
  input  logic       clk,
  input  site_mode_t mode,
  input  logic       ce_in,
  input  logic       sr_in,
  output logic       ff_clk,
  output logic       latch_gate,
  output logic       ce_eff,
  output logic       sr_eff,
  output logic       ff_sr_async,
  output logic       ff_sr_sync
);

  // Flip-flops: bit set selects the falling edge.
  assign ff_clk = clk ^ mode.clk_inv;

  assign ce_eff = mode.use_ce ? ce_in : 1'b1;
  assign sr_eff = mode.use_sr & sr_in;

  // Latches: bit clear inverts the gate; enable qualifies it.
  assign latch_gate = (clk ^ ~mode.clk_inv) & ce_eff;

  assign ff_sr_async = sr_eff & ~mode.sync_sr;
  assign ff_sr_sync  = sr_eff &  mode.sync_sr;

endmodule

// File: rtl/slice_ff_cell.sv
module slice_ff_cell (
  input  logic cap_clk,
  input  logic gsr,
  input  logic sr_async,
  input  logic sr_sync,
  input  logic ce,
  input  logic d,
  input  logic sr_val,
  input  logic gsr_val,
  output logic q
);

  always_ff @(posedge cap_clk or posedge gsr or posedge sr_async) begin
    if (gsr)           q <= gsr_val;
    else if (sr_async) q <= sr_val;
    else if (sr_sync)  q <= sr_val;
    else if (ce)       q <= d;
  end

endmodule

// File: rtl/slice_latch_cell.sv
module slice_latch_cell (
  input  logic gate,
  input  logic gsr,
  input  logic sr,
  input  logic d,
  input  logic sr_val,
  input  logic gsr_val,
  output logic q
);

  always_latch begin
    if (gsr)       q <= gsr_val;
    else if (sr)   q <= sr_val;
    else if (gate) q <= d;
  end

endmodule

// File: rtl/slice_storage_bank.sv
module slice_storage_bank
  import slice_store_pkg::*;
#(
  parameter int NUM_PRI = 4,
  parameter int NUM_SEC = 4
) (
  input  logic                         clk,
  input  logic                         gsr_in,
  input  logic                         ce_in,
  input  logic                         sr_in,
  input  logic [NUM_PRI+NUM_SEC-1:0]   d_in,
  input  logic                         mode_latch,
  input  logic                         mode_sync_sr,
  input  logic                         mode_clk_inv,
  input  logic                         mode_use_ce,
  input  logic                         mode_use_sr,
  input  logic [NUM_PRI+NUM_SEC-1:0]   elem_rst_sel,
  input  logic [NUM_PRI+NUM_SEC-1:0]   elem_init_sel,
  output logic [NUM_PRI+NUM_SEC-1:0]   q_out
);

  localparam int NUM_EL = NUM_PRI + NUM_SEC;

  site_mode_t mode;
  logic ff_clk, latch_gate, ce_eff, sr_eff, ff_sr_async, ff_sr_sync;

  assign mode = '{latch:   mode_latch,
                  sync_sr: mode_sync_sr,
                  clk_inv: mode_clk_inv,
                  use_ce:  mode_use_ce,
                  use_sr:  mode_use_sr};

  slice_site_ctrl u_ctrl (
    .clk         (clk),
    .mode        (mode),
    .ce_in       (ce_in),
    .sr_in       (sr_in),
    .ff_clk      (ff_clk),
    .latch_gate  (latch_gate),
    .ce_eff      (ce_eff),
    .sr_eff      (sr_eff),
    .ff_sr_async (ff_sr_async),
    .ff_sr_sync  (ff_sr_sync)
  );

  for (genvar i = 0; i < NUM_EL; i++) begin : g_el
    logic ff_q;

    slice_ff_cell u_ff (
      .cap_clk  (ff_clk),
      .gsr      (gsr_in),
      .sr_async (ff_sr_async),
      .sr_sync  (ff_sr_sync),
      .ce       (ce_eff),
      .d        (d_in[i]),
      .sr_val   (sr_level(elem_rst_sel[i])),
      .gsr_val  (gsr_level(elem_init_sel[i], 1'b0)),
      .q        (ff_q)
    );

    if (i < NUM_PRI) begin : g_pri
      logic lat_q;

      slice_latch_cell u_lat (
        .gate    (latch_gate),
        .gsr     (gsr_in),
        .sr      (sr_eff),
        .d       (d_in[i]),
        .sr_val  (sr_level(elem_rst_sel[i])),
        .gsr_val (gsr_level(elem_init_sel[i], 1'b1)),
        .q       (lat_q)
      );

      assign q_out[i] = mode.latch ? lat_q : ff_q;
    end else begin : g_sec
      assign q_out[i] = mode.latch ? 1'b0 : ff_q;
    end
  end

endmodule

// File: rtl/slice_storage_bank_chk.sv
module slice_storage_bank_chk #(
  parameter int NUM_PRI = 4,
  parameter int NUM_SEC = 4
) (
  input logic                       clk,
  input logic                       gsr_in,
  input logic                       ce_in,
  input logic                       sr_in,
  input logic                       mode_latch,
  input logic                       mode_clk_inv,
  input logic                       mode_use_ce,
  input logic                       mode_use_sr,
  input logic [NUM_PRI+NUM_SEC-1:0] elem_rst_sel,
  input logic [NUM_PRI+NUM_SEC-1:0] elem_init_sel,
  input logic [NUM_PRI+NUM_SEC-1:0] q_out
);

  localparam int NUM_EL = NUM_PRI + NUM_SEC;

  logic [NUM_EL-1:0] gsr_expect;
  logic [NUM_EL-1:0] init_prev;
  logic              latch_prev;
  logic              gsr_prev;

  always_comb begin
    for (int i = 0; i < NUM_EL; i++) begin
      if (mode_latch) gsr_expect[i] = (i < NUM_PRI) ? elem_init_sel[i] : 1'b0;
      else            gsr_expect[i] = ~elem_init_sel[i];
    end
  end

  // R1 R2: global set/reset held with a steady selector loads the mapped value
  always_ff @(negedge clk) begin
    gsr_prev   <= gsr_in;
    init_prev  <= elem_init_sel;
    latch_prev <= mode_latch;
    if (gsr_in && gsr_prev && init_prev == elem_init_sel && latch_prev == mode_latch) begin
      gsr_load_chk: assert (q_out == gsr_expect)
        else $error("gsr load mismatch q=%b exp=%b", q_out, gsr_expect);
    end
  end

  // R10
  sec_off_chk: assert property (@(posedge clk) disable iff (gsr_in)
    mode_latch |-> (q_out[NUM_EL-1:NUM_PRI] == '0));

  // R6
  sr_level_chk: assert property (@(posedge clk) disable iff (gsr_in)
    (!mode_latch && !mode_clk_inv && mode_use_sr && sr_in)
      |=> (q_out == ~$past(elem_rst_sel)));

  // R7
  ce_hold_chk: assert property (@(posedge clk) disable iff (gsr_in)
    (!mode_latch && !mode_clk_inv && mode_use_ce && !ce_in && !mode_use_sr)
      |=> $stable(q_out));

endmodule

bind slice_storage_bank slice_storage_bank_chk #(.NUM_PRI(NUM_PRI), .NUM_SEC(NUM_SEC)) u_chk (
  .clk           (clk),
  .gsr_in        (gsr_in),
  .ce_in         (ce_in),
  .sr_in         (sr_in),
  .mode_latch    (mode_latch),
  .mode_clk_inv  (mode_clk_inv),
  .mode_use_ce   (mode_use_ce),
  .mode_use_sr   (mode_use_sr),
  .elem_rst_sel  (elem_rst_sel),
  .elem_init_sel (elem_init_sel),
  .q_out         (q_out)
);

// File: tb/tb_slice_storage_bank.sv
`timescale 1ns/1ps
module tb_slice_storage_bank;

  logic       clk = 1'b0;
  logic       gsr = 1'b0, ce = 1'b0, sr = 1'b0;
  logic [7:0] d = '0;
  logic       m_latch = 0, m_sync = 0, m_inv = 0, m_ce = 0, m_sr = 0;
  logic [7:0] rst_sel = 8'h00;
  logic [7:0] init_sel = 8'hA5;
  logic [7:0] q;
  logic [7:0] m;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  slice_storage_bank dut (
    .clk(clk), .gsr_in(gsr), .ce_in(ce), .sr_in(sr), .d_in(d),
    .mode_latch(m_latch), .mode_sync_sr(m_sync), .mode_clk_inv(m_inv),
    .mode_use_ce(m_ce), .mode_use_sr(m_sr),
    .elem_rst_sel(rst_sel), .elem_init_sel(init_sel), .q_out(q)
  );

  function automatic logic [7:0] mdl(input logic [7:0] cur, input logic [7:0] di,
                                     input logic cei, input logic sri, input logic gi);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (m_latch && i >= 4)    r[i] = 1'b0;
      else if (gi)              r[i] = m_latch ? init_sel[i] : ~init_sel[i];
      else if (m_sr && sri)     r[i] = ~rst_sel[i];
      else if (!m_ce || cei)    r[i] = di[i];
      else                      r[i] = cur[i];
    end
    return r;
  endfunction

  function automatic logic [15:0] lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Entered at rising edge + 1 ns; leaves at the next rising edge + 1 ns.
  task automatic step(input string tag, input logic [7:0] di, input logic cei,
                      input logic sri, input logic gi);
    d = di; ce = cei; sr = sri; gsr = gi;
    m = mdl(m, di, cei, sri, gi);
    @(posedge clk); #1;
    chk(tag, q, m);
  endtask

  task automatic set_mode(input string tag, input logic [4:0] bits,
                          input logic [7:0] rs, input logic [7:0] is);
    gsr = 1'b1;
    {m_latch, m_sync, m_inv, m_ce, m_sr} = bits;
    rst_sel = rs; init_sel = is;
    step(tag, 8'h00, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_reset_state;
    m = ~init_sel;
    @(posedge clk); #1;
    chk("R1 reset state", q, 8'h5A);
    set_mode("R1 init polarity", 5'b00000, 8'h00, 8'h0F);
    chk("R1 ff init", q, 8'hF0);
  endtask

  task automatic t_latch_init;
    set_mode("R2 latch init", 5'b10100, 8'h00, 8'hF6);
    chk("R2 latch init value", q, 8'h06);
    chk("R10 secondary zero under gsr", {q[7:4], 4'h0}, 8'h00);
  endtask

  task automatic t_edges;
    set_mode("R3 setup", 5'b00000, 8'h00, 8'h00);
    step("R3 release", 8'h00, 1'b0, 1'b0, 1'b0);
    d = 8'hA5;
    #2 chk("R3 rising: none before falling", q, 8'h00);
    #2 chk("R3 rising: none on falling edge", q, 8'h00);
    @(posedge clk); #1 chk("R3 rising capture", q, 8'hA5);
    set_mode("R3 setup inv", 5'b00100, 8'h00, 8'h00);
    step("R3 release inv", 8'h00, 1'b0, 1'b0, 1'b0);
    d = 8'h3C;
    #2 chk("R3 falling: none on rising", q, 8'h00);
    #2 chk("R3 falling capture", q, 8'h3C);
    @(posedge clk); #1 chk("R3 falling hold", q, 8'h3C);
    m = 8'h3C;
  endtask

  task automatic t_latch_gate;
    set_mode("R4 setup", 5'b10110, 8'h00, 8'h00);
    step("R4 release", 8'h00, 1'b0, 1'b0, 1'b0);
    d = 8'hFF; ce = 1'b1;
    #1 chk("R4 transparent gate high", q, 8'h0F);
    #3 d = 8'h05;
    #1 chk("R4 hold gate low", q, 8'h0F);
    @(posedge clk); #1 chk("R4 reopen", q, 8'h05);
    ce = 1'b0; d = 8'hFA;
    #1 chk("R7 latch gate disabled", q, 8'h05);
    set_mode("R4 setup inv", 5'b10010, 8'h00, 8'h00);
    step("R4 release inv", 8'h00, 1'b0, 1'b0, 1'b0);
    d = 8'h09; ce = 1'b1;
    #1 chk("R4 inverted gate closed", q, 8'h00);
    #4 chk("R4 inverted gate open", q, 8'h09);
    @(posedge clk); #1;
    m = 8'h09;
  endtask

  task automatic t_sr_timing;
    set_mode("R5 setup async", 5'b00001, 8'hC3, 8'h00);
    step("R5 release", 8'hFF, 1'b0, 1'b0, 1'b0);
    sr = 1'b1;
    #1 chk("R5 async immediate / R6 levels", q, 8'h3C);
    @(posedge clk); #1 chk("R6 held under sr", q, 8'h3C);
    m = 8'h3C;
    step("R5 after sr", 8'hFF, 1'b0, 1'b0, 1'b0);
    set_mode("R5 setup sync", 5'b01001, 8'hC3, 8'h00);
    step("R5 release sync", 8'hFF, 1'b0, 1'b0, 1'b0);
    sr = 1'b1;
    #1 chk("R5 sync waits for edge", q, 8'hFF);
    @(posedge clk); #1 chk("R5 sync at edge", q, 8'h3C);
    m = 8'h3C;
    set_mode("R5 setup latch", 5'b11101, 8'h05, 8'h00);
    step("R5 latch release", 8'h0F, 1'b0, 1'b0, 1'b0);
    sr = 1'b1;
    #1 chk("R5 latch immediate", q, 8'h0A);
    @(posedge clk); #1;
    m = 8'h0A;
  endtask

  task automatic t_ce_sr;
    set_mode("R7 setup", 5'b00010, 8'h00, 8'h00);
    step("R7 ce high", 8'h11, 1'b1, 1'b0, 1'b0);
    step("R7 ce low holds", 8'h22, 1'b0, 1'b0, 1'b0);
    chk("R7 hold value", q, 8'h11);
    set_mode("R8 setup", 5'b00000, 8'hFF, 8'h00);
    step("R7 ce ignored", 8'h33, 1'b0, 1'b0, 1'b0);
    chk("R7 forced enable", q, 8'h33);
    step("R8 sr ignored", 8'h44, 1'b0, 1'b1, 1'b0);
    chk("R8 data captured despite sr", q, 8'h44);
  endtask

  task automatic t_priority;
    set_mode("R9 setup", 5'b00011, 8'h0F, 8'h33);
    step("R9 release", 8'h55, 1'b1, 1'b0, 1'b0);
    step("R9 sr over data", 8'hAA, 1'b1, 1'b1, 1'b0);
    chk("R9 sr wins", q, 8'hF0);
    step("R9 gsr over sr", 8'hAA, 1'b1, 1'b1, 1'b1);
    chk("R9 gsr wins", q, 8'hCC);
  endtask

  task automatic t_sweep;
    logic [15:0] lf = 16'hACE1;
    for (int c = 0; c < 32; c++) begin
      lf = lfsr(lf); lf = lfsr(lf);
      set_mode("R11 sweep gsr", c[4:0], lf[7:0], lf[15:8]);
      for (int k = 0; k < 12; k++) begin
        lf = lfsr(lf);
        step("R11 sweep", lf[7:0], lf[8], lf[9] & lf[10], 1'b0);
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: q=%b expected completion", q);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1 gsr = 1'b1;
    t_reset_state();
    t_latch_init();
    t_edges();
    t_latch_gate();
    t_sr_timing();
    t_ce_sr();
    t_priority();
    t_sweep();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule